// File: doc/BRIEF.md
# Received Frame Sorter

This block sits between the link layer and the host transport logic of a serial storage host port. Each incoming frame arrives as a stream of 32-bit words, with the first word marked as start and the last marked as end. The low byte of the first word is the frame type. Data frames lose that header word, and their payload goes in order into a receive FIFO that a downstream DMA drains. Every other frame type is copied into its own fixed window of a small received-frame RAM, and a status flag for that type is raised when the frame ends. Types the block does not recognise go to a catch-all window and raise an unknown-frame flag.

The status flags are cleared by writing ones to them. An enable register masks the flags into one interrupt line. An external pulse reports that a descriptor has been processed. A register frame with its error bit set raises a task-file error flag. The block also exports the command tag carried by a DMA setup frame as a one-cycle event. When the receive FIFO is full, the block stalls the link through its ready output, so no payload word is lost.

Top module: `rx_frame_sorter`

## Requirements
- R1: After reset the status flags and the enable register are zero, `intrOut` and `outValid` are low, and `inReady` is high.
- R2: The type is taken from bits [7:0] of the start word. 0x34 is a device-to-host register frame (status bit 0), 0x5F is a PIO setup frame (bit 1), 0x41 is a DMA setup frame (bit 2), 0xA1 is a set-device-bits frame (bit 3), and 0x46 is a data frame. Any other code is unknown (bit 4). The flag for a non-data frame is visible on `stsOut` in the cycle after its end word is accepted.
- R3: Non-data frames are written into the RAM starting at these word addresses: DMA setup at 0 (7 words), PIO setup at 8 (5 words), register at 16 (5 words), set-device-bits at 22 (2 words), unknown at 24 (16 words). Words past a window's length are discarded, and no other address is written.
- R4: A data frame writes no RAM word and sets no status flag. Its start word is dropped, and every later word enters the FIFO in arrival order.
- R5: `inReady` is low exactly while the FIFO is full. Every payload word accepted is later delivered on `outData`.
- R6: A register frame whose start word has bit 16 set (the error bit of its status byte) also sets status bit 6 (task-file error).
- R7: When `stsWrEn` is high, each 1 in `stsWrData` clears that status bit, and each 0 leaves its bit unchanged. If a bit is set and cleared in the same cycle, the set wins.
- R8: `ieWrEn` loads `ieWrData` into the enable register. `intrOut` is the OR of all status bits whose enable bit is set.
- R9: A one-cycle pulse on `descDone` sets status bit 5.
- R10: When the second word of a DMA setup frame is accepted, `tagValid` is high for one cycle, starting in the next cycle, and `tag` carries bits [4:0] of that word.
- R11: A word without the start mark that arrives while no frame is open has no effect. A start mark always opens a new frame.
- R12: `ramRdData` returns the RAM word at `ramRdAddr` one cycle after the address is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Link word valid |
| inData | input | 32 | Link word |
| inSop | input | 1 | First word of a frame |
| inEop | input | 1 | Last word of a frame |
| inReady | output | 1 | Word accepted when high with inValid |
| outValid | output | 1 | FIFO has a payload word |
| outData | output | 32 | FIFO head word |
| outReady | input | 1 | Consumer takes the head word |
| ramRdAddr | input | 6 | Received-frame RAM word address |
| ramRdData | output | 32 | RAM read data, one cycle later |
| stsWrEn | input | 1 | Write-one-to-clear strobe for status |
| stsWrData | input | 7 | Bits to clear |
| ieWrEn | input | 1 | Enable register write strobe |
| ieWrData | input | 7 | New enable value |
| descDone | input | 1 | Descriptor processed pulse |
| stsOut | output | 7 | Status flags |
| ieOut | output | 7 | Enable register |
| intrOut | output | 1 | Interrupt request |
| tagValid | output | 1 | DMA setup tag event |
| tag | output | 5 | DMA setup tag |

## Verification
The assertions check several rules on every cycle. A status flag only rises when a frame end or the descriptor pulse drives it. A write of ones leaves no flag set unless a set arrived in the same cycle. At most one frame-type flag is raised per word. A word never goes to both the RAM and the FIFO. A full FIFO always presents data. The bench scenarios are what show the rest: the window addresses, truncation of long frames, header stripping and payload order, the tag value, the fact that stray words are ignored, and no word lost under a long stall.

// File: rtl/rfs_pkg.sv
package rfs_pkg;
  localparam int WordW    = 32;
  localparam int NumSts   = 7;
  localparam int RamWords = 40;
  localparam int RamAw    = 6;
  localparam int TagW     = 5;

  localparam int StD2h  = 0;
  localparam int StPio  = 1;
  localparam int StDset = 2;
  localparam int StSdb  = 3;
  localparam int StUnk  = 4;
  localparam int StDesc = 5;
  localparam int StTfe  = 6;

  typedef enum logic [2:0] {
    KD2h  = 3'd0,
    KPio  = 3'd1,
    KDset = 3'd2,
    KSdb  = 3'd3,
    KUnk  = 3'd4,
    KData = 3'd5
  } kind_e;

  typedef struct packed {
    logic              ramWe;
    logic [RamAw-1:0]  ramAddr;
    logic [WordW-1:0]  wrData;
    logic              fifoPush;
    logic [NumSts-1:0] setMask;
    logic              tagValid;
    logic [TagW-1:0]   tag;
  } strobe_t;

  function automatic kind_e decodeKind(input logic [7:0] code);
    case (code)
      8'h34:   return KD2h;
      8'h5F:   return KPio;
      8'h41:   return KDset;
      8'hA1:   return KSdb;
      8'h46:   return KData;
      default: return KUnk;
    endcase
  endfunction

  function automatic logic [RamAw-1:0] regionBase(input kind_e k);
    case (k)
      KDset:   return RamAw'(0);
      KPio:    return RamAw'(8);
      KD2h:    return RamAw'(16);
      KSdb:    return RamAw'(22);
      default: return RamAw'(24);
    endcase
  endfunction

  function automatic logic [RamAw-1:0] regionLen(input kind_e k);
    case (k)
      KDset:   return RamAw'(7);
      KPio:    return RamAw'(5);
      KD2h:    return RamAw'(5);
      KSdb:    return RamAw'(2);
      KUnk:    return RamAw'(16);
      default: return RamAw'(0);
    endcase
  endfunction
endpackage

// File: rtl/rfs_ctrl.sv
module rfs_ctrl
  import rfs_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [WordW-1:0] inData,
  input  logic             inSop,
  input  logic             inEop,
  input  logic             inReady,
  output strobe_t          strb
);
  localparam int IdxW = 5;
  localparam logic [IdxW-1:0] IdxMax = {IdxW{1'b1}};

  logic            inFrame;
  kind_e           kindQ;
  logic [IdxW-1:0] idxQ;
  logic            errQ;

  logic            take;
  kind_e           kindNow;
  logic [IdxW-1:0] idxNow;
  logic            errNow;

  assign take    = inValid && inReady && (inSop || inFrame);
  assign kindNow = inSop ? decodeKind(inData[7:0]) : kindQ;
  assign idxNow  = inSop ? '0 : idxQ;
  assign errNow  = inSop ? inData[16] : errQ;

  always_comb begin
    strb          = '0;
    strb.wrData   = inData;
    strb.ramAddr  = regionBase(kindNow) + RamAw'(idxNow);
    strb.ramWe    = take && (kindNow != KData) &&
                    (RamAw'(idxNow) < regionLen(kindNow));
    strb.fifoPush = take && (kindNow == KData) && (idxNow != '0);
    strb.tagValid = take && (kindNow == KDset) && (idxNow == IdxW'(1));
    strb.tag      = inData[TagW-1:0];
    if (take && inEop) begin
      case (kindNow)
        KD2h: begin
          strb.setMask[StD2h] = 1'b1;
          strb.setMask[StTfe] = errNow;
        end
        KPio:    strb.setMask[StPio]  = 1'b1;
        KDset:   strb.setMask[StDset] = 1'b1;
        KSdb:    strb.setMask[StSdb]  = 1'b1;
        KUnk:    strb.setMask[StUnk]  = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inFrame <= 1'b0;
      kindQ   <= KUnk;
      idxQ    <= '0;
      errQ    <= 1'b0;
    end else if (take) begin
      inFrame <= !inEop;
      kindQ   <= kindNow;
      errQ    <= errNow;
      idxQ    <= (idxNow == IdxMax) ? IdxMax : idxNow + IdxW'(1);
    end
  end
endmodule

// File: rtl/rfs_data.sv
module rfs_data
  import rfs_pkg::*;
#(
  parameter int FifoDepth = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic              descDone,
  input  logic              stsWrEn,
  input  logic [NumSts-1:0] stsWrData,
  input  logic              ieWrEn,
  input  logic [NumSts-1:0] ieWrData,
  input  logic [RamAw-1:0]  ramRdAddr,
  output logic [WordW-1:0]  ramRdData,
  input  logic              outReady,
  output logic              outValid,
  output logic [WordW-1:0]  outData,
  output logic              inReady,
  output logic [NumSts-1:0] stsOut,
  output logic [NumSts-1:0] ieOut,
  output logic              intrOut,
  output logic              tagValid,
  output logic [TagW-1:0]   tag
);
  localparam int PtrW = (FifoDepth > 1) ? $clog2(FifoDepth) : 1;
  localparam int CntW = $clog2(FifoDepth + 1);
  localparam logic [PtrW-1:0] PtrLast = PtrW'(FifoDepth - 1);
  localparam logic [CntW-1:0] CntFull = CntW'(FifoDepth);

  logic [WordW-1:0] fifoMem [FifoDepth];
  logic [PtrW-1:0]  wrPtr, rdPtr;
  logic [CntW-1:0]  count;
  logic             push, pop;

  assign inReady  = (count != CntFull);
  assign outValid = (count != '0);
  assign outData  = fifoMem[rdPtr];
  assign push     = strb.fifoPush;
  assign pop      = outValid && outReady;

  always_ff @(posedge clk) begin
    if (push) fifoMem[wrPtr] <= strb.wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= (wrPtr == PtrLast) ? '0 : wrPtr + PtrW'(1);
      if (pop)  rdPtr <= (rdPtr == PtrLast) ? '0 : rdPtr + PtrW'(1);
      case ({push, pop})
        2'b10:   count <= count + CntW'(1);
        2'b01:   count <= count - CntW'(1);
        default: ;
      endcase
    end
  end

  logic [WordW-1:0] frameRam [RamWords];

  always_ff @(posedge clk) begin
    if (strb.ramWe) frameRam[strb.ramAddr] <= strb.wrData;
    ramRdData <= (ramRdAddr < RamAw'(RamWords)) ? frameRam[ramRdAddr] : '0;
  end

  logic [NumSts-1:0] stsQ, ieQ, setAll, clrMask;

  always_comb begin
    setAll         = strb.setMask;
    setAll[StDesc] = strb.setMask[StDesc] | descDone;
    clrMask        = stsWrEn ? stsWrData : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stsQ     <= '0;
      ieQ      <= '0;
      tagValid <= 1'b0;
      tag      <= '0;
    end else begin
      stsQ     <= (stsQ & ~clrMask) | setAll;
      if (ieWrEn) ieQ <= ieWrData;
      tagValid <= strb.tagValid;
      if (strb.tagValid) tag <= strb.tag;
    end
  end

  assign stsOut  = stsQ;
  assign ieOut   = ieQ;
  assign intrOut = |(stsQ & ieQ);
endmodule

// File: rtl/rx_frame_sorter.sv
module rx_frame_sorter
  import rfs_pkg::*;
#(
  parameter int FifoDepth = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [WordW-1:0]  inData,
  input  logic              inSop,
  input  logic              inEop,
  output logic              inReady,
  output logic              outValid,
  output logic [WordW-1:0]  outData,
  input  logic              outReady,
  input  logic [RamAw-1:0]  ramRdAddr,
  output logic [WordW-1:0]  ramRdData,
  input  logic              stsWrEn,
  input  logic [NumSts-1:0] stsWrData,
  input  logic              ieWrEn,
  input  logic [NumSts-1:0] ieWrData,
  input  logic              descDone,
  output logic [NumSts-1:0] stsOut,
  output logic [NumSts-1:0] ieOut,
  output logic              intrOut,
  output logic              tagValid,
  output logic [TagW-1:0]   tag
);
  strobe_t strb;

  rfs_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .inData  (inData),
    .inSop   (inSop),
    .inEop   (inEop),
    .inReady (inReady),
    .strb    (strb)
  );

  rfs_data #(.FifoDepth(FifoDepth)) u_data (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .descDone  (descDone),
    .stsWrEn   (stsWrEn),
    .stsWrData (stsWrData),
    .ieWrEn    (ieWrEn),
    .ieWrData  (ieWrData),
    .ramRdAddr (ramRdAddr),
    .ramRdData (ramRdData),
    .outReady  (outReady),
    .outValid  (outValid),
    .outData   (outData),
    .inReady   (inReady),
    .stsOut    (stsOut),
    .ieOut     (ieOut),
    .intrOut   (intrOut),
    .tagValid  (tagValid),
    .tag       (tag)
  );
endmodule

// File: rtl/rx_frame_sorter_chk.sv
module rx_frame_sorter_chk
  import rfs_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              inReady,
  input logic              outValid,
  input logic              stsWrEn,
  input logic [NumSts-1:0] stsWrData,
  input logic              descDone,
  input logic [NumSts-1:0] stsOut,
  input logic [NumSts-1:0] ieOut,
  input logic              intrOut,
  input strobe_t           stb
);
  logic [NumSts-1:0] setAll;
  always_comb begin
    setAll         = stb.setMask;
    setAll[StDesc] = stb.setMask[StDesc] | descDone;
  end

  // R2: a flag only rises when a frame end or the descriptor pulse drove it
  a_r2_set_needs_source: assert property (@(posedge clk) disable iff (!rstN)
    ((stsOut & ~$past(stsOut) & ~$past(setAll)) == '0));

  // R2: at most one frame-type flag per accepted word
  a_r2_single_kind: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(stb.setMask[StUnk:StD2h]));

  // R4: a word goes to the RAM or the FIFO, never both
  a_r4_ram_or_fifo: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.ramWe && stb.fifoPush));

  // R5: a stalled link means a full FIFO that holds data
  a_r5_stall_has_data: assert property (@(posedge clk) disable iff (!rstN)
    !inReady |-> outValid);

  // R7: written ones clear unless a set came in the same cycle
  a_r7_w1c: assert property (@(posedge clk) disable iff (!rstN)
    stsWrEn |=> ((stsOut & $past(stsWrData) & ~$past(setAll)) == '0));

  // R8: nothing enabled, no interrupt
  a_r8_masked_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (ieOut == '0) |-> !intrOut);
endmodule

bind rx_frame_sorter rx_frame_sorter_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .inReady   (inReady),
  .outValid  (outValid),
  .stsWrEn   (stsWrEn),
  .stsWrData (stsWrData),
  .descDone  (descDone),
  .stsOut    (stsOut),
  .ieOut     (ieOut),
  .intrOut   (intrOut),
  .stb       (strb)
);

// File: tb/rx_frame_sorter_bench.sv
module rx_frame_sorter_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] inData = '0;
  logic        inSop = 1'b0, inEop = 1'b0;
  logic        inReady, outValid, outReady = 1'b1;
  logic [31:0] outData, ramRdData;
  logic [5:0]  ramRdAddr = '0;
  logic        stsWrEn = 1'b0, ieWrEn = 1'b0, descDone = 1'b0;
  logic [6:0]  stsWrData = '0, ieWrData = '0;
  logic [6:0]  stsOut, ieOut;
  logic        intrOut, tagValid;
  logic [4:0]  tag;

  always #2 clk = ~clk;

  rx_frame_sorter u_rx_frame_sorter (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData), .inSop(inSop),
    .inEop(inEop), .inReady(inReady), .outValid(outValid), .outData(outData),
    .outReady(outReady), .ramRdAddr(ramRdAddr), .ramRdData(ramRdData),
    .stsWrEn(stsWrEn), .stsWrData(stsWrData), .ieWrEn(ieWrEn), .ieWrData(ieWrData),
    .descDone(descDone), .stsOut(stsOut), .ieOut(ieOut), .intrOut(intrOut),
    .tagValid(tagValid), .tag(tag)
  );

  int total = 0;
  int bad = 0;
  logic [31:0] expQ[$];
  logic [31:0] frm [0:31];
  bit sawStall = 0;
  bit tagSeen = 0;
  logic [4:0] tagVal = '0;
  logic [31:0] rd;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN && outValid && outReady) begin
      if (expQ.size() == 0) chk(0, "R4 unexpected payload", outData, 32'h0);
      else begin
        logic [31:0] e;
        e = expQ.pop_front();
        chk(outData == e, "R4/R5 payload order", outData, e);
      end
    end
    if (rstN && tagValid) begin
      tagSeen = 1;
      tagVal  = tag;
    end
  end

  task automatic putWord(input logic [31:0] d, input bit sop, input bit eop);
    @(negedge clk);
    inValid = 1; inData = d; inSop = sop; inEop = eop;
    while (!inReady) begin
      sawStall = 1;
      @(negedge clk);
    end
    @(posedge clk);
    #1;
    inValid = 0; inSop = 0; inEop = 0;
  endtask

  task automatic sendFrame(input int n);
    for (int i = 0; i < n; i++) putWord(frm[i], i == 0, i == n - 1);
  endtask

  task automatic sendData(input int n, input logic [31:0] base);
    frm[0] = 32'h0000_0046;
    for (int i = 1; i <= n; i++) begin
      frm[i] = base + i;
      expQ.push_back(base + i);
    end
    sendFrame(n + 1);
  endtask

  task automatic fillFrame(input logic [31:0] w0, input int n, input logic [31:0] base);
    frm[0] = w0;
    for (int i = 1; i < n; i++) frm[i] = base + i;
  endtask

  task automatic readRam(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    ramRdAddr = a;
    @(negedge clk);
    d = ramRdData;
  endtask

  task automatic writeSts(input logic [6:0] m);
    @(negedge clk);
    stsWrEn = 1; stsWrData = m;
    @(negedge clk);
    stsWrEn = 0; stsWrData = '0;
  endtask

  task automatic writeIe(input logic [6:0] m);
    @(negedge clk);
    ieWrEn = 1; ieWrData = m;
    @(negedge clk);
    ieWrEn = 0;
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    chk(stsOut == 0, "R1 status", stsOut, 0);
    chk(ieOut == 0 && !intrOut, "R1 enable/irq", {ieOut, intrOut}, 0);
    chk(!outValid && inReady, "R1 fifo", {outValid, inReady}, 32'h1);

    // R2 register frame, enables off
    fillFrame(32'h0050_0034, 5, 32'hD200_0000);
    sendFrame(5);
    @(negedge clk);
    chk(stsOut == 7'h01, "R2 register flag", stsOut, 7'h01);
    chk(!intrOut, "R8 masked", intrOut, 0);
    readRam(16, rd); chk(rd == 32'h0050_0034, "R3/R12 reg window first", rd, 32'h0050_0034);
    readRam(20, rd); chk(rd == 32'hD200_0004, "R3 reg window last", rd, 32'hD200_0004);

    // R8 enable, R7 w1c
    writeIe(7'h01);
    chk(intrOut, "R8 enabled irq", intrOut, 1);
    writeSts(7'h00);
    chk(stsOut == 7'h01, "R7 zero write no effect", stsOut, 7'h01);
    writeSts(7'h01);
    chk(stsOut == 7'h00 && !intrOut, "R7 clear", {intrOut, stsOut}, 0);

    // R6 error bit
    fillFrame(32'h0051_0034, 5, 32'hD300_0000);
    sendFrame(5);
    @(negedge clk);
    chk(stsOut == 7'h41, "R6 task-file error", stsOut, 7'h41);
    writeSts(7'h7F);

    // PIO setup
    fillFrame(32'h0000_005F, 5, 32'hB000_0000);
    sendFrame(5);
    @(negedge clk);
    chk(stsOut == 7'h02, "R2 pio flag", stsOut, 7'h02);
    readRam(8, rd); chk(rd == 32'h0000_005F, "R3 pio window", rd, 32'h5F);

    // DMA setup with tag
    fillFrame(32'h0000_0041, 7, 32'hC000_0000);
    frm[1] = 32'hC000_0013;
    sendFrame(7);
    @(negedge clk);
    chk(stsOut == 7'h06, "R2 dma setup flag", stsOut, 7'h06);
    chk(tagSeen && tagVal == 5'd19, "R10 tag", {tagSeen, tagVal}, {1'b1, 5'd19});
    readRam(6, rd); chk(rd == 32'hC000_0006, "R3 dma window last", rd, 32'hC000_0006);

    // set-device-bits
    fillFrame(32'h0000_00A1, 2, 32'hA000_0000);
    sendFrame(2);
    @(negedge clk);
    chk(stsOut == 7'h0E, "R2 sdb flag", stsOut, 7'h0E);
    readRam(23, rd); chk(rd == 32'hA000_0001, "R3 sdb window", rd, 32'hA000_0001);

    // long register frame is truncated
    fillFrame(32'h0050_0034, 7, 32'hD400_0000);
    sendFrame(7);
    readRam(20, rd); chk(rd == 32'hD400_0004, "R3 truncated last", rd, 32'hD400_0004);
    readRam(22, rd); chk(rd == 32'h0000_00A1, "R3 neighbour intact", rd, 32'hA1);

    // unknown type, 20 words
    fillFrame(32'h0000_0027, 20, 32'hEE00_0000);
    sendFrame(20);
    @(negedge clk);
    chk(stsOut[4], "R2 unknown flag", stsOut, 7'h1F);
    readRam(24, rd); chk(rd == 32'h0000_0027, "R3 unknown first", rd, 32'h27);
    readRam(39, rd); chk(rd == 32'hEE00_000F, "R3 unknown truncated", rd, 32'hEE00_000F);
    readRam(0, rd); chk(rd == 32'h0000_0041, "R3 dma intact", rd, 32'h41);
    writeSts(7'h7F);

    // data frame
    sendData(4, 32'h1100_0000);
    repeat (6) @(negedge clk);
    chk(stsOut == 0, "R4 no flag for data", stsOut, 0);
    chk(expQ.size() == 0, "R4 all payload seen", expQ.size(), 0);

    // stray word
    putWord(32'h0000_0034, 0, 1);
    repeat (2) @(negedge clk);
    chk(stsOut == 0 && !outValid, "R11 stray ignored", {outValid, stsOut}, 0);

    // descriptor pulse and set-wins
    @(negedge clk); descDone = 1;
    @(negedge clk); descDone = 0;
    chk(stsOut == 7'h20, "R9 descriptor flag", stsOut, 7'h20);
    @(negedge clk); descDone = 1; stsWrEn = 1; stsWrData = 7'h20;
    @(negedge clk); descDone = 0; stsWrEn = 0; stsWrData = 0;
    chk(stsOut == 7'h20, "R7 set wins", stsOut, 7'h20);

    // backpressure
    outReady = 0;
    fork
      sendData(12, 32'h2200_0000);
      begin repeat (25) @(negedge clk); outReady = 1; end
    join
    repeat (15) @(negedge clk);
    chk(sawStall, "R5 stall seen", sawStall, 1);
    chk(expQ.size() == 0, "R5 no loss", expQ.size(), 0);

    summary();
  end
endmodule